// File: doc/BRIEF.md
# Package Emulation Controller

This block holds a small package-selection code that tells the rest of the chip which package outline to behave as. At reset it takes a build-time default naming the device's true package. From the active code it derives a per-pin input-enable mask for a 32-pin port. Pins that the selected package does not bond out have their input path forced low. Output drivers are never touched by this block.

Software may replace the code exactly once per reset while the chip runs in normal mode. In special mode the one-shot lock is bypassed and any number of writes land. A request for a package bigger than the real one cannot take effect: the reserved illegal code is stored in its place. While that code is held, the mask falls back to the real package's mask.

Top module: `pkg_emul_ctrl`

## Requirements
- R1: After reset `code_o` equals parameter `DEV_CODE` (default 3'd5), `lock_o` is 0, and `ie_mask_o` is the mask of `DEV_CODE`.
- R2: With `special_mode_i`=0 and `lock_o`=0, a cycle with `wr_en_i`=1 stores the write data. After that clock edge `code_o` shows the stored code and `lock_o` is 1.
- R3: With `special_mode_i`=0 and `lock_o`=1, writes are ignored: `code_o`, `ie_mask_o` and `lock_o` keep their values until the next reset.
- R4: With `special_mode_i`=1 every write is accepted and `lock_o` is left unchanged.
- R5: Write data numerically greater than `DEV_CODE` stores the illegal code 3'b111 instead of the data. In normal mode such a write still sets the lock.
- R6: For a legal code c (0 to 6), `ie_mask_o` has its low floor(32*(c+1)/7) bits set and all other bits clear. Bit p is pin p.
- R7: While `code_o` is 3'b111, `ie_mask_o` equals the mask of `DEV_CODE`.
- R8: `ie_mask_o` is registered and changes at the same clock edge as `code_o`, one edge after the accepted write strobe.
- R9: `core_in_o[p]` follows `pad_in_i[p]` combinationally when `ie_mask_o[p]`=1, and is 0 otherwise.
- R10: In a cycle with `wr_en_i`=0, `code_o`, `lock_o` and `ie_mask_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| special_mode_i | input | 1 | 1 = special mode, bypasses the write lock |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_data_i | input | 3 | Requested package code |
| code_o | output | 3 | Stored package code |
| lock_o | output | 1 | 1 once a normal-mode write has been taken |
| ie_mask_o | output | 32 | Per-pin input-buffer enable |
| pad_in_i | input | 32 | Raw pad input values |
| core_in_o | output | 32 | Pad inputs after input-enable gating |

## Verification
The code, the lock flag and the mask are all due on the first rising edge after the strobe cycle. The bench raises the strobe on a falling edge and drops it on the next falling edge. It reads all three results at that same falling edge, half a period after they change. Gated pad inputs are combinational, so they are checked a short delay after the pad pattern is applied, with no clock edge in between. Ignored writes are confirmed by reading the outputs after the edge that would have captured them.

// File: rtl/pkg_emul_pkg.sv
package pkg_emul_pkg;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned NUM_LEGAL = (1 << CODE_W) - 1;

  typedef logic [CODE_W-1:0] pkg_code_t;

  localparam pkg_code_t ILLEGAL_CODE = '1;

  // pins bonded out for a legal code; grows with the code value
  function automatic int unsigned pins_bonded(input pkg_code_t code, input int unsigned num_pins);
    int unsigned c;
    c = int'(code);
    return (num_pins * (c + 1)) / NUM_LEGAL;
  endfunction
endpackage

// File: rtl/pkg_write_guard.sv
module pkg_write_guard
  import pkg_emul_pkg::*;
#(
  parameter pkg_code_t DEV_CODE = 3'd5
) (
  input  logic      wr_en_i,
  input  pkg_code_t wr_data_i,
  input  logic      special_i,
  input  logic      lock_i,
  input  pkg_code_t code_q_i,
  output pkg_code_t code_d_o,
  output logic      lock_d_o
);
  logic      accept;
  logic      oversize;
  pkg_code_t store_code;

  assign accept     = wr_en_i & (special_i | ~lock_i);
  assign oversize   = (wr_data_i > DEV_CODE);
  assign store_code = oversize ? ILLEGAL_CODE : wr_data_i;

  // only a normal-mode write consumes the one-shot
  assign lock_d_o = lock_i | (accept & ~special_i);
  assign code_d_o = accept ? store_code : code_q_i;
endmodule

// File: rtl/pkg_mask_map.sv
module pkg_mask_map
  import pkg_emul_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter pkg_code_t   DEV_CODE = 3'd5
) (
  input  pkg_code_t           code_i,
  output logic [NUM_PINS-1:0] mask_o
);
  pkg_code_t   eff_code;
  int unsigned n_pins;

  assign eff_code = (code_i == ILLEGAL_CODE) ? DEV_CODE : code_i;
  assign n_pins   = pins_bonded(eff_code, NUM_PINS);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int unsigned PIN_IDX = p;
    assign mask_o[p] = (PIN_IDX < n_pins);
  end
endmodule

// File: rtl/pkg_code_reg.sv
module pkg_code_reg
  import pkg_emul_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter pkg_code_t   DEV_CODE = 3'd5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  pkg_code_t           code_d_i,
  input  logic                lock_d_i,
  input  logic [NUM_PINS-1:0] mask_d_i,
  input  logic [NUM_PINS-1:0] mask_rst_i,
  output pkg_code_t           code_q_o,
  output logic                lock_q_o,
  output logic [NUM_PINS-1:0] mask_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q_o <= DEV_CODE;
      lock_q_o <= 1'b0;
      mask_q_o <= mask_rst_i;
    end else begin
      code_q_o <= code_d_i;
      lock_q_o <= lock_d_i;
      mask_q_o <= mask_d_i;
    end
  end
endmodule

// File: rtl/pkg_emul_ctrl.sv
module pkg_emul_ctrl
  import pkg_emul_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter pkg_code_t   DEV_CODE = 3'd5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                special_mode_i,
  input  logic                wr_en_i,
  input  logic [CODE_W-1:0]   wr_data_i,
  output logic [CODE_W-1:0]   code_o,
  output logic                lock_o,
  output logic [NUM_PINS-1:0] ie_mask_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] core_in_o
);
  pkg_code_t           code_q, code_d;
  logic                lock_q, lock_d;
  logic [NUM_PINS-1:0] mask_d, mask_rst, mask_q;

  pkg_write_guard #(.DEV_CODE(DEV_CODE)) u_guard (
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .special_i(special_mode_i),
    .lock_i   (lock_q),
    .code_q_i (code_q),
    .code_d_o (code_d),
    .lock_d_o (lock_d)
  );

  // mask follows the next code so both land on the same edge
  pkg_mask_map #(.NUM_PINS(NUM_PINS), .DEV_CODE(DEV_CODE)) u_map_next (
    .code_i(code_d),
    .mask_o(mask_d)
  );

  pkg_mask_map #(.NUM_PINS(NUM_PINS), .DEV_CODE(DEV_CODE)) u_map_rst (
    .code_i(DEV_CODE),
    .mask_o(mask_rst)
  );

  pkg_code_reg #(.NUM_PINS(NUM_PINS), .DEV_CODE(DEV_CODE)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_d_i  (code_d),
    .lock_d_i  (lock_d),
    .mask_d_i  (mask_d),
    .mask_rst_i(mask_rst),
    .code_q_o  (code_q),
    .lock_q_o  (lock_q),
    .mask_q_o  (mask_q)
  );

  assign code_o    = code_q;
  assign lock_o    = lock_q;
  assign ie_mask_o = mask_q;

  // input side only; outputs of absent pins are not gated here
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_gate
    assign core_in_o[p] = pad_in_i[p] & mask_q[p];
  end
endmodule

// File: rtl/pkg_emul_chk.sv
module pkg_emul_chk
  import pkg_emul_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter pkg_code_t   DEV_CODE = 3'd5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                special_mode_i,
  input logic                wr_en_i,
  input logic [CODE_W-1:0]   wr_data_i,
  input logic [CODE_W-1:0]   code_o,
  input logic                lock_o,
  input logic [NUM_PINS-1:0] ie_mask_o,
  input logic [NUM_PINS-1:0] core_in_o
);
  a_r2_first_write_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !special_mode_i && !lock_o) |=> lock_o);

  a_r3_locked_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !special_mode_i && lock_o) |=> ($stable(code_o) && $stable(ie_mask_o) && lock_o));

  a_r4_special_keeps_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && special_mode_i) |=> (lock_o == $past(lock_o)));

  a_r5_oversize_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (special_mode_i || !lock_o) && (wr_data_i > DEV_CODE)) |=> (code_o == ILLEGAL_CODE));

  a_r6_mask_low_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((ie_mask_o + 1'b1) & ie_mask_o) == '0));

  a_r9_absent_pins_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((core_in_o & ~ie_mask_o) == '0));

  a_r10_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(code_o) && $stable(lock_o) && $stable(ie_mask_o)));
endmodule

bind pkg_emul_ctrl pkg_emul_chk #(.NUM_PINS(NUM_PINS), .DEV_CODE(DEV_CODE)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .special_mode_i(special_mode_i),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .code_o        (code_o),
  .lock_o        (lock_o),
  .ie_mask_o     (ie_mask_o),
  .core_in_o     (core_in_o)
);

// File: tb/pkg_emul_ctrl_tb.sv
module pkg_emul_ctrl_tb;
  localparam int NP  = 32;
  localparam int DEV = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          special = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_data = '0;
  logic [2:0]    code;
  logic          lock;
  logic [NP-1:0] mask;
  logic [NP-1:0] pad = '0;
  logic [NP-1:0] core_in;

  int n_checks = 0;
  int n_errs   = 0;

  always #10 clk = ~clk;

  pkg_emul_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .special_mode_i(special),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .code_o(code), .lock_o(lock),
    .ie_mask_o(mask), .pad_in_i(pad), .core_in_o(core_in)
  );

  // {special, data, expected code, expected lock}; starts right after reset
  localparam logic [7:0] VEC [8] = '{
    {1'b0, 3'd2, 3'd2, 1'b1},
    {1'b0, 3'd4, 3'd2, 1'b1},
    {1'b1, 3'd0, 3'd0, 1'b1},
    {1'b1, 3'd6, 3'd7, 1'b1},
    {1'b1, 3'd3, 3'd3, 1'b1},
    {1'b0, 3'd1, 3'd3, 1'b1},
    {1'b1, 3'd5, 3'd5, 1'b1},
    {1'b1, 3'd7, 3'd7, 1'b1}
  };

  function automatic logic [NP-1:0] exp_mask(input logic [2:0] c);
    int eff, n;
    eff = (c == 3'd7) ? DEV : int'(c);
    n = (NP * (eff + 1)) / 7;
    return (n >= NP) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  task automatic check(input string req, input logic ok, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [2:0] c, input logic l);
    check(req, code === c, NP'(code), NP'(c));
    check(req, lock === l, NP'(lock), NP'(l));
    check(req, mask === exp_mask(c), mask, exp_mask(c));
  endtask

  task automatic do_write(input logic sp, input logic [2:0] d);
    @(negedge clk);
    special = sp; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; special = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset", 3'(DEV), 1'b0);

    // R2 R3 R4 R5 R6 R7 R8 vector walk
    for (int i = 0; i < 8; i++) begin
      do_write(VEC[i][7], VEC[i][6:4]);
      check_state($sformatf("R8 vec%0d R2/R3/R4/R5/R6/R7", i), VEC[i][3:1], VEC[i][0]);
    end

    // R5 R7: oversize in normal mode stores illegal and locks
    do_reset();
    check_state("R1 re-reset", 3'(DEV), 1'b0);
    do_write(1'b0, 3'd6);
    check_state("R5 oversize normal", 3'd7, 1'b1);
    check("R7 fallback mask", mask === exp_mask(3'(DEV)), mask, exp_mask(3'(DEV)));
    do_write(1'b0, 3'd0);
    check_state("R3 locked after illegal", 3'd7, 1'b1);

    // R4: special writes leave lock clear, then a normal write still allowed
    do_reset();
    do_write(1'b1, 3'd1);
    check_state("R4 special no lock", 3'd1, 1'b0);
    do_write(1'b0, 3'd4);
    check_state("R2 normal after special", 3'd4, 1'b1);

    // R10: idle cycles with data toggling
    @(negedge clk); wr_data = 3'd0; special = 1'b1;
    repeat (3) @(negedge clk);
    special = 1'b0;
    check_state("R10 idle", 3'd4, 1'b1);

    // R6 smallest package and R9 gating
    do_reset();
    do_write(1'b0, 3'd0);
    check_state("R6 code0", 3'd0, 1'b1);
    pad = 32'hFFFF_FFFF; #1;
    check("R9 all-ones pads", core_in === 32'h0000_000F, core_in, 32'h0000_000F);
    pad = 32'hA5A5_A5A5; #1;
    check("R9 pattern pads", core_in === 32'h0000_0005, core_in, 32'h0000_0005);
    do_reset();
    #1;
    check("R9 dev package", core_in === (32'hA5A5_A5A5 & exp_mask(3'(DEV))), core_in,
          32'hA5A5_A5A5 & exp_mask(3'(DEV)));

    finish_run();
  end
endmodule